// File: doc/BRIEF.md
# Pipelined GF(2^8) Field Inverter

This block returns the multiplicative inverse of an element of GF(2^M) in polynomial basis. The default is M = 8, with the irreducible polynomial x^8 + x^4 + x^3 + x + 1 fixed by a parameter. It is fully pipelined. The block accepts one element with a valid flag on every clock. It returns each inverse with its own valid flag after a fixed number of cycles. It never stalls and never pushes back.

The inverse is computed as A^(2^M - 2). The block starts from B = A and applies the step B <- A * B^2 a total of M - 2 times, which gives A^(2^(M-1) - 1). A final squaring then gives the inverse.

Each step has one stage for squaring and M stages for the multiply. The multiply stages form a bit-level semi-systolic array. Each of these stages handles one bit of the carried operand, most significant bit first. The original operand travels beside every partial result, so each stage multiplies by the operand of its own data item.

The total latency is LAT = (M-2)(M+1) + 2, which is 56 cycles when M = 8. Zero is defined to map to zero.

Top module: `gf_inv_pipe`

## Requirements
- R1: An element sampled with in_valid high at clock edge k gives out_valid high in the cycle that follows edge k+LAT-1, where LAT = (M-2)(M+1)+2 = 56. out_valid is never high at any other time.
- R2: For every nonzero input X, the output Y satisfies X*Y = 1 in GF(2^8). Products are reduced modulo 0x11B (x^8+x^4+x^3+x+1), and bit i of a value is the coefficient of x^i.
- R3: An input of 0 sampled with in_valid high gives out_valid high with out_inv = 0 after the same latency.
- R4: Inputs on consecutive cycles give outputs on consecutive cycles. Each output carries the inverse of its own input, with no mixing between neighbours. A burst of 256 inputs gives a run of exactly 256 valid outputs.
- R5: out_inv is all zeros in every cycle in which out_valid is low.
- R6: While rst_n is low, and for LAT-1 cycles after it is released, out_valid stays low. Items that were in flight when reset was asserted never appear at the output.
- R7: in_elem has no effect in cycles where in_valid is low. It produces no output, and it does not disturb the results of valid items before or after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every stage |
| in_valid | input | 1 | High when in_elem holds an element to invert |
| in_elem | input | M | Field element to invert, polynomial basis |
| out_valid | output | 1 | High when out_inv holds a result |
| out_inv | output | M | Inverse of the element that entered LAT cycles earlier |

## Verification
The hardest situation to reach from the ports is a pipeline full of distinct items with gaps in unusual places. In that situation, an operand carried in the wrong stage, or a result belonging to a neighbour, would show up as a wrong inverse. Back-to-back bursts across all 256 values create the full pipeline. A sparse pattern feeds changing data while in_valid is low, which puts junk next to live items. A reset asserted with about forty items in flight shows that none of them escape. Every output cycle is compared against a delayed queue filled from a brute-force inverse table.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;
    // Default field: degree and irreducible polynomial (bit i = coefficient of x^i)
    localparam int unsigned GF_DEG  = 8;
    localparam logic [GF_DEG:0] GF_POLY = 9'h11B;
endpackage

// File: rtl/gfinv_sqr.sv
// Combinational squarer: spread bits to even positions, then reduce from the top.
module gfinv_sqr #(
    parameter int unsigned M    = gfinv_pkg::GF_DEG,
    parameter logic [M:0]  POLY = gfinv_pkg::GF_POLY
) (
    input  logic [M-1:0] x_i,
    output logic [M-1:0] sq_o
);
    localparam int unsigned WIDE = 2 * M - 1;

    logic [WIDE-1:0] wide;

    always_comb begin
        wide = '0;
        for (int i = 0; i < M; i++) begin
            wide[2*i] = x_i[i];
        end
        for (int k = WIDE - 1; k >= M; k--) begin
            if (wide[k]) begin
                wide[k -: M+1] = wide[k -: M+1] ^ POLY;
            end
        end
        sq_o = wide[M-1:0];
    end
endmodule

// File: rtl/gfinv_mac.sv
// One cell row of the semi-systolic multiplier: acc*x + (sel ? addend : 0).
module gfinv_mac #(
    parameter int unsigned M    = gfinv_pkg::GF_DEG,
    parameter logic [M:0]  POLY = gfinv_pkg::GF_POLY
) (
    input  logic [M-1:0] acc_i,
    input  logic [M-1:0] addend_i,
    input  logic         sel_i,
    output logic [M-1:0] acc_o
);
    logic [M-1:0] shifted;

    always_comb begin
        shifted = {acc_i[M-2:0], 1'b0};
        if (acc_i[M-1]) begin
            shifted = shifted ^ POLY[M-1:0];
        end
        acc_o = shifted ^ (sel_i ? addend_i : '0);
    end
endmodule

// File: rtl/gfinv_step.sv
// One recurrence step B <- A * B^2: a squaring stage, then M multiplier rows.
module gfinv_step #(
    parameter int unsigned M    = gfinv_pkg::GF_DEG,
    parameter logic [M:0]  POLY = gfinv_pkg::GF_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic [M-1:0] b_i,
    input  logic [M-1:0] a_i,
    output logic         v_o,
    output logic [M-1:0] b_o,
    output logic [M-1:0] a_o
);
    typedef struct packed {
        logic         v;
        logic [M-1:0] s;
        logic [M-1:0] a;
    } sq_t;

    typedef struct packed {
        logic         v;
        logic [M-1:0] acc;
        logic [M-1:0] s;
        logic [M-1:0] a;
    } row_t;

    sq_t  sq_d, sq_q;
    row_t row_d [M];
    row_t row_q [M];

    logic [M-1:0] b_sq;
    logic [M-1:0] mac_acc [M];
    logic [M-1:0] mac_add [M];
    logic         mac_sel [M];
    logic [M-1:0] mac_out [M];

    gfinv_sqr #(.M(M), .POLY(POLY)) u_sqr (
        .x_i  (b_i),
        .sq_o (b_sq)
    );

    // Row r consumes carried-operand bit M-1-r (MSB first)
    for (genvar r = 0; r < M; r++) begin : g_row
        if (r == 0) begin : g_first
            assign mac_acc[r] = '0;
            assign mac_add[r] = sq_q.s;
            assign mac_sel[r] = sq_q.a[M-1];
        end else begin : g_next
            assign mac_acc[r] = row_q[r-1].acc;
            assign mac_add[r] = row_q[r-1].s;
            assign mac_sel[r] = row_q[r-1].a[M-1-r];
        end
        gfinv_mac #(.M(M), .POLY(POLY)) u_mac (
            .acc_i    (mac_acc[r]),
            .addend_i (mac_add[r]),
            .sel_i    (mac_sel[r]),
            .acc_o    (mac_out[r])
        );
    end

    always_comb begin
        sq_d.v = v_i;
        sq_d.s = b_sq;
        sq_d.a = a_i;
        for (int r = 0; r < M; r++) begin
            if (r == 0) begin
                row_d[r].v = sq_q.v;
                row_d[r].s = sq_q.s;
                row_d[r].a = sq_q.a;
            end else begin
                row_d[r].v = row_q[r-1].v;
                row_d[r].s = row_q[r-1].s;
                row_d[r].a = row_q[r-1].a;
            end
            row_d[r].acc = mac_out[r];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
            for (int r = 0; r < M; r++) begin
                row_q[r] <= '0;
            end
        end else begin
            sq_q <= sq_d;
            for (int r = 0; r < M; r++) begin
                row_q[r] <= row_d[r];
            end
        end
    end

    assign v_o = row_q[M-1].v;
    assign b_o = row_q[M-1].acc;
    assign a_o = row_q[M-1].a;
endmodule

// File: rtl/gf_inv_pipe.sv
// Fully pipelined inverter: input register, M-2 square-then-multiply steps,
// final squaring into the output register.
module gf_inv_pipe #(
    parameter int unsigned M    = gfinv_pkg::GF_DEG,
    parameter logic [M:0]  POLY = gfinv_pkg::GF_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [M-1:0] in_elem,
    output logic         out_valid,
    output logic [M-1:0] out_inv
);
    localparam int unsigned NSTEP    = M - 2;
    localparam int unsigned STEP_LAT = M + 1;
    localparam int unsigned LAT      = NSTEP * STEP_LAT + 2;

    typedef struct packed {
        logic         v;
        logic [M-1:0] e;
    } ent_t;

    typedef struct packed {
        logic         v;
        logic [M-1:0] inv;
    } res_t;

    typedef struct packed {
        ent_t ent;
        res_t res;
    } pipe_t;

    pipe_t d, q;

    logic         link_v [NSTEP+1];
    logic [M-1:0] link_b [NSTEP+1];
    logic [M-1:0] link_a [NSTEP+1];
    logic [M-1:0] fin_sq;

    assign link_v[0] = q.ent.v;
    assign link_b[0] = q.ent.e;
    assign link_a[0] = q.ent.e;

    for (genvar s = 0; s < NSTEP; s++) begin : g_step
        gfinv_step #(.M(M), .POLY(POLY)) u_step (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (link_v[s]),
            .b_i   (link_b[s]),
            .a_i   (link_a[s]),
            .v_o   (link_v[s+1]),
            .b_o   (link_b[s+1]),
            .a_o   (link_a[s+1])
        );
    end

    gfinv_sqr #(.M(M), .POLY(POLY)) u_fin_sqr (
        .x_i  (link_b[NSTEP]),
        .sq_o (fin_sq)
    );

    always_comb begin
        // Idle slots carry zero so the output is quiet when not valid
        d.ent.v   = in_valid;
        d.ent.e   = in_valid ? in_elem : '0;
        d.res.v   = link_v[NSTEP];
        // The carried operand picks the defined zero result explicitly
        d.res.inv = (link_a[NSTEP] == '0) ? '0 : fin_sq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.res.v;
    assign out_inv   = q.res.inv;
endmodule

// File: rtl/gf_inv_pipe_chk.sv
module gf_inv_pipe_chk #(
    parameter int unsigned M    = 8,
    parameter logic [M:0]  POLY = 9'h11B,
    parameter int unsigned LAT  = 56
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [M-1:0] in_elem,
    input logic         out_valid,
    input logic [M-1:0] out_inv
);
    logic         hv_q [LAT];
    logic [M-1:0] hd_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                hv_q[i] <= 1'b0;
                hd_q[i] <= '0;
            end
        end else begin
            hv_q[0] <= in_valid;
            hd_q[0] <= in_valid ? in_elem : '0;
            for (int i = 1; i < LAT; i++) begin
                hv_q[i] <= hv_q[i-1];
                hd_q[i] <= hd_q[i-1];
            end
        end
    end

    function automatic logic [M-1:0] fmul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [M-1:0] r;
        r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            r = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY[M-1:0] : '0);
            if (y[i]) r = r ^ x;
        end
        return r;
    endfunction

    // R1 and R6: output valid is the input valid delayed by LAT
    p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hv_q[LAT-1]);

    // R2: product of output and its own input is one
    p_inverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hd_q[LAT-1] != '0) |-> (fmul(out_inv, hd_q[LAT-1]) == {{(M-1){1'b0}}, 1'b1}));

    // R3: zero maps to zero
    p_zero_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hd_q[LAT-1] == '0) |-> (out_inv == '0));

    // R4: consecutive inputs leave as consecutive outputs
    p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hv_q[LAT-2]) |=> out_valid);

    // R5: quiet data when not valid
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_inv == '0));
endmodule

bind gf_inv_pipe gf_inv_pipe_chk #(.M(M), .POLY(POLY), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_elem   (in_elem),
    .out_valid (out_valid),
    .out_inv   (out_inv)
);

// File: tb/gf_inv_pipe_tb_top.sv
module gf_inv_pipe_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int M          = 8;
    localparam int LAT        = (M - 2) * (M + 1) + 2;
    localparam int WD_CYCLES  = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [M-1:0] in_elem = '0;
    logic         out_valid;
    logic [M-1:0] out_inv;

    gf_inv_pipe dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_elem   (in_elem),
        .out_valid (out_valid),
        .out_inv   (out_inv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int        inv_tab [256];
    int        checks = 0;
    int        failures = 0;
    bit        done = 1'b0;
    logic [M:0] exp_q [$];
    logic [M:0] cur = '0;
    string     phase = "reset";
    int        run = 0;
    int        max_run = 0;

    // Behavioural field product: schoolbook polynomial product, then reduce by 0x11B
    function automatic int ref_mul(int a, int b);
        int p;
        p = 0;
        for (int i = 0; i < 8; i++) if ((b >> i) & 1) p = p ^ (a << i);
        for (int k = 14; k >= 8; k--) if ((p >> k) & 1) p = p ^ ('h11B << (k - 8));
        return p;
    endfunction

    function automatic int ref_inv(int a);
        if (a == 0) return 0;
        for (int x = 1; x < 256; x++) if (ref_mul(a, x) == 1) return x;
        return -1;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h (phase %s)", tag, what, act, expv, phase);
        end
    endtask

    // Reference model: delayed queue of expected outputs, compared every cycle
    always @(posedge clk) begin
        logic [M-1:0] e;
        if (!rst_n) begin
            exp_q.delete();
            for (int i = 0; i < LAT - 1; i++) exp_q.push_back('0);
            cur = '0;
        end else begin
            e = M'(inv_tab[in_elem]);
            exp_q.push_back(in_valid ? {1'b1, e} : '0);
            cur = exp_q.pop_front();
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            check(out_valid === cur[M], (phase == "reset") ? "R6" : "R1",
                  "out_valid", int'(out_valid), int'(cur[M]));
            if (cur[M]) begin
                check(out_inv === cur[M-1:0],
                      (cur[M-1:0] == '0) ? "R3" : ((phase == "burst") ? "R4" : "R2"),
                      "out_inv", int'(out_inv), int'(cur[M-1:0]));
            end else begin
                check(out_inv === '0, (phase == "sparse") ? "R7" : "R5",
                      "idle out_inv", int'(out_inv), 0);
            end
            if (out_valid === 1'b1) run++;
            else run = 0;
            if (run > max_run) max_run = run;
        end
    end

    task automatic drive(bit v, logic [M-1:0] e);
        @(negedge clk);
        in_valid = v;
        in_elem  = e;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", WD_CYCLES, WD_CYCLES);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) inv_tab[i] = ref_inv(i);

        // Reset state (R6)
        phase = "reset";
        repeat (4) @(negedge clk);
        check(out_valid === 1'b0, "R6", "out_valid in reset", int'(out_valid), 0);
        check(out_inv === '0, "R6", "out_inv in reset", int'(out_inv), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // Isolated items: latency and values (R1, R2, R3)
        phase = "single";
        drive(1'b1, 8'h01); idle(LAT + 2);
        drive(1'b1, 8'h53); idle(LAT + 2);
        drive(1'b1, 8'h00); idle(LAT + 2);
        drive(1'b1, 8'hFF); idle(LAT + 2);

        // Full sweep back to back (R2, R3, R4)
        phase = "burst";
        max_run = 0;
        for (int i = 0; i < 256; i++) drive(1'b1, M'(i));
        idle(LAT + 4);
        check(max_run == 256, "R4", "longest valid run", max_run, 256);

        // Junk on in_elem while in_valid is low, around live items (R7)
        phase = "sparse";
        for (int i = 0; i < 300; i++) drive((i % 3) == 1, M'((i * 7 + 11) % 256));
        for (int i = 0; i < 60; i++) drive((i % 2) == 0, M'((i * 29 + 3) % 256));
        idle(LAT + 4);

        // Reset with items in flight (R6)
        phase = "reset";
        for (int i = 0; i < 40; i++) drive(1'b1, M'(i * 5 + 1));
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R6", "out_valid during mid-run reset", int'(out_valid), 0);
        rst_n = 1'b1;
        idle(LAT + 4);

        // Recovery after reset
        phase = "single";
        drive(1'b1, 8'hC3);
        drive(1'b1, 8'h02);
        idle(LAT + 4);

        finish_run();
    end
endmodule